// File: doc/BRIEF.md
# Privileged Instruction Trap Unit

This block sits next to the decode stage of a 12-bit accumulator CPU. It enforces two privilege levels: executive and user. In executive mode every fetched instruction runs unchanged. In user mode the block inspects each valid instruction word. If the word is an I/O transfer, a halt, or a switch-register read, the block blocks execution in that same cycle. On the next clock edge it drops the machine back to executive mode, latches the offending word and raises a sticky trap request. The interrupt path uses that request to enter the kernel.

The kernel reads the latched word and can treat it as a service call. It clears the request with an acknowledge pulse. To return to user code it issues a mode-set command. That command is armed and does not act at once. The first valid fetch after it, normally the return jump, still runs privileged. User mode applies from the clock edge after that fetch.

Bit numbering in the requirements counts from the most significant bit: bit 0 is `instr_word[11]` and bit 11 is `instr_word[0]`.

Top module: `priv_trap_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters executive mode. After that edge `user_mode` is 0, `trap_req` is 0, `trap_word` is 0 and `suppress` is 0.
- R2: In executive mode (`user_mode` = 0), `suppress` stays 0 for every word, including I/O transfers, halt and switch-register reads. No trap is raised.
- R3: In user mode, a valid word whose bits 0–2 equal octal 6 (an I/O transfer, including the memory-field-switch transfers) drives `suppress` high in that same cycle.
- R4: In user mode, a valid group-2 operate word drives `suppress` high when its halt bit (bit 10) is set. A group-2 operate word has bits 0–2 equal to octal 7, bit 3 set and bit 11 clear.
- R5: In user mode, a valid group-2 operate word drives `suppress` high when its switch-register bit (bit 9) is set. This covers both the plain OR-with-switches and the clear-and-load-switches forms.
- R6: In user mode, memory-reference words, group-1 operate words (bit 3 clear) and group-3 operate words (bit 3 and bit 11 set) do not drive `suppress` high, even when bits 9 or 10 are set.
- R7: On the edge that ends a suppressed cycle, `user_mode` falls to 0, `trap_req` rises to 1 and `trap_word` takes the suppressed word. `trap_word` then holds that value until the next trap.
- R8: `trap_req` stays at 1 until a `trap_ack` pulse clears it at the next edge. If a trap and `trap_ack` fall in the same cycle, the trap wins and `trap_req` stays at 1.
- R9: A `set_user` pulse arms the mode change. The first valid fetch after the pulse runs in executive mode and is not suppressed, even when it is forbidden. `user_mode` rises at the edge that ends that fetch.
- R10: When `instr_valid` is low, `suppress` is 0 and no mode, request or latched-word state changes, whatever `instr_word` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 12 | Fetched instruction word |
| instr_valid | input | 1 | Qualifies `instr_word` as a fetch this cycle |
| set_user | input | 1 | Kernel command: arm a return to user mode |
| trap_ack | input | 1 | Kernel acknowledge, clears the trap request |
| trap_req | output | 1 | Sticky trap request toward the interrupt path |
| suppress | output | 1 | Blocks execution of the current word (combinational) |
| trap_word | output | 12 | Latched copy of the last trapped word |
| user_mode | output | 1 | Current privilege level, 1 = user |

## Verification
The request flag has two functions that can meet in one cycle: a new trap setting it and a kernel acknowledge clearing it. To provoke this, the bench leaves one trap unacknowledged and returns to user mode. It then presents a switch-register read with `trap_ack` asserted on the same fetch. The expected result is that `trap_req` stays at 1, `trap_word` takes the new word and `user_mode` drops. A second clash is also checked: a forbidden word arriving as the first fetch after the mode-set command. It must run unsuppressed and then enable user mode.

// File: rtl/ptu_pkg.sv
// ptu_pkg: shared widths, opcode values and field types for the privileged
// instruction trap unit. Bit positions use MSB-first numbering (bit 0 is the
// most significant bit of the word), converted to vector indices here.
package ptu_pkg;

    localparam int WORD_W = 12;
    localparam int OPC_W  = 3;

    // index in a [WORD_W-1:0] vector of MSB-first bit n
    localparam int OPC_HI     = WORD_W - 1;
    localparam int OPC_LO     = WORD_W - OPC_W;
    localparam int GRP_IDX    = WORD_W - 1 - 3;   // bit 3: operate group select
    localparam int SWREG_IDX  = WORD_W - 1 - 9;   // bit 9: switch-register read
    localparam int HALT_IDX   = WORD_W - 1 - 10;  // bit 10: halt
    localparam int SUBGRP_IDX = WORD_W - 1 - 11;  // bit 11: group 2 vs 3

    localparam logic [OPC_W-1:0] OPC_IOT = 3'o6;
    localparam logic [OPC_W-1:0] OPC_OPR = 3'o7;

    // fields of the word that the privilege decoder needs
    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic             grp_sel;
        logic             swreg;
        logic             halt;
        logic             subgrp;
    } ptu_fields_t;

    // forbidden-class flags produced by the decoder
    typedef struct packed {
        logic is_io;
        logic is_halt;
        logic is_swreg;
    } ptu_class_t;

endpackage

// File: rtl/ptu_decode.sv
// ptu_decode: classifies a fetched word into the forbidden classes.
// Pure combinational; assumes the fields were sliced with ptu_pkg indices.
module ptu_decode
    import ptu_pkg::*;
(
    input  ptu_fields_t fields,
    output ptu_class_t  cls,
    output logic        forbidden
);

    logic grp2_opr;

    // identify a group-2 operate word
    always_comb begin
        grp2_opr = (fields.opcode == OPC_OPR) && fields.grp_sel && !fields.subgrp;
    end

    // derive class flags and the combined forbidden indication
    always_comb begin
        cls.is_io    = (fields.opcode == OPC_IOT);
        cls.is_halt  = grp2_opr && fields.halt;
        cls.is_swreg = grp2_opr && fields.swreg;
        forbidden    = cls.is_io | cls.is_halt | cls.is_swreg;
    end

endmodule

// File: rtl/ptu_mode_ctrl.sv
// ptu_mode_ctrl: holds the privilege level. A mode-set command arms a
// deferred entry to user mode that completes after the next valid fetch.
// A trap forces executive mode and cancels any armed entry.
module ptu_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid,
    input  logic set_user,
    input  logic trap,
    output logic user_mode
);

    logic armed;

    // track an armed return request
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed <= 1'b0;
        else if (trap)                 armed <= 1'b0;
        else if (set_user)             armed <= 1'b1;
        else if (instr_valid && armed) armed <= 1'b0;
    end

    // privilege level update: trap first, then deferred entry
    always_ff @(posedge clk) begin
        if (!rst_n)                    user_mode <= 1'b0;
        else if (trap)                 user_mode <= 1'b0;
        else if (armed && instr_valid) user_mode <= 1'b1;
    end

    // R7
    trap_leaves_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !user_mode);

    // R9
    user_entry_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_mode) |-> $past(armed && instr_valid));

endmodule

// File: rtl/ptu_trap_latch.sv
// ptu_trap_latch: captures the trapped word and holds the sticky request.
// Assumes trap is a one-cycle strobe that is aligned with the word.
module ptu_trap_latch
    import ptu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap,
    input  logic              trap_ack,
    input  logic [WORD_W-1:0] word_in,
    output logic              pending,
    output logic [WORD_W-1:0] word_out
);

    // sticky request: a trap wins over an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (trap)     pending <= 1'b1;
        else if (trap_ack) pending <= 1'b0;
    end

    // capture the offending word
    always_ff @(posedge clk) begin
        if (!rst_n)    word_out <= '0;
        else if (trap) word_out <= word_in;
    end

    // R7
    trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (pending && word_out == $past(word_in)));

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ack && !trap) |=> !pending);

    // R8
    pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !trap_ack) |=> pending);

endmodule

// File: rtl/priv_trap_unit.sv
// priv_trap_unit: top of the privileged instruction trap unit. It slices the
// fetched word, decodes the forbidden classes, blocks them in user mode and
// hands trap state to the mode controller and the trap latch.
module priv_trap_unit
    import ptu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              instr_valid,
    input  logic              set_user,
    input  logic              trap_ack,
    output logic              trap_req,
    output logic              suppress,
    output logic [WORD_W-1:0] trap_word,
    output logic              user_mode
);

    ptu_fields_t fields;
    ptu_class_t  cls;
    logic        forbidden;
    logic        trap;

    // slice the decoder fields out of the word
    always_comb begin
        fields.opcode  = instr_word[OPC_HI:OPC_LO];
        fields.grp_sel = instr_word[GRP_IDX];
        fields.swreg   = instr_word[SWREG_IDX];
        fields.halt    = instr_word[HALT_IDX];
        fields.subgrp  = instr_word[SUBGRP_IDX];
    end

    ptu_decode u_decode (
        .fields    (fields),
        .cls       (cls),
        .forbidden (forbidden)
    );

    // block a forbidden fetch in user mode; it is also the trap strobe
    always_comb begin
        trap     = instr_valid && user_mode && forbidden;
        suppress = trap;
    end

    ptu_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .set_user    (set_user),
        .trap        (trap),
        .user_mode   (user_mode)
    );

    ptu_trap_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap),
        .trap_ack (trap_ack),
        .word_in  (instr_word),
        .pending  (trap_req),
        .word_out (trap_word)
    );

    // R2
    exec_no_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> !suppress);

    // R10
    idle_no_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !suppress);

    // R10
    idle_state_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !set_user && !trap_ack) |=>
            ($stable(trap_word) && $stable(trap_req)));

    // R3
    io_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && user_mode && cls.is_io) |-> suppress);

endmodule

// File: tb/priv_trap_unit_test.sv
module priv_trap_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] instr_word = '0;
    logic        instr_valid = 1'b0;
    logic        set_user = 1'b0;
    logic        trap_ack = 1'b0;
    logic        trap_req;
    logic        suppress;
    logic [11:0] trap_word;
    logic        user_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic        supp;
        logic        usr;
        logic        req;
        logic [11:0] word;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    priv_trap_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_word  (instr_word),
        .instr_valid (instr_valid),
        .set_user    (set_user),
        .trap_ack    (trap_ack),
        .trap_req    (trap_req),
        .suppress    (suppress),
        .trap_word   (trap_word),
        .user_mode   (user_mode)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %o expected %o", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected results
    task automatic cyc(string tag, logic v, logic [11:0] w, logic su, logic ak,
                       logic e_supp, logic e_usr, logic e_req, logic [11:0] e_word);
        exp_t it;
        @(negedge clk);
        #1;
        instr_valid = v;
        instr_word  = w;
        set_user    = su;
        trap_ack    = ak;
        it.tag = tag; it.supp = e_supp; it.usr = e_usr; it.req = e_req; it.word = e_word;
        q.push_back(it);
    endtask

    // monitor: suppress before the edge, state after it
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #4;
            if (q.size() > 0) begin
                it = q.pop_front();
                cmp(it.tag, "suppress", int'(suppress), int'(it.supp));
                @(posedge clk);
                #1;
                cmp(it.tag, "user_mode", int'(user_mode), int'(it.usr));
                cmp(it.tag, "trap_req", int'(trap_req), int'(it.req));
                cmp(it.tag, "trap_word", int'(trap_word), int'(it.word));
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        cmp("R1", "user_mode", int'(user_mode), 0);
        cmp("R1", "trap_req", int'(trap_req), 0);
        cmp("R1", "trap_word", int'(trap_word), 0);
        cmp("R1", "suppress", int'(suppress), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 executive mode runs everything
        cyc("R2", 1, 12'o6031, 0, 0, 0, 0, 0, 12'o0);
        cyc("R2", 1, 12'o7402, 0, 0, 0, 0, 0, 12'o0);
        cyc("R2", 1, 12'o7404, 0, 0, 0, 0, 0, 12'o0);
        // R9 arm, then a forbidden first fetch runs privileged
        cyc("R9", 0, 12'o0000, 1, 0, 0, 0, 0, 12'o0);
        cyc("R9", 1, 12'o6031, 0, 0, 0, 1, 0, 12'o0);
        // R6 permitted words in user mode
        cyc("R6", 1, 12'o1234, 0, 0, 0, 1, 0, 12'o0);
        cyc("R6", 1, 12'o7006, 0, 0, 0, 1, 0, 12'o0);
        cyc("R6", 1, 12'o7403, 0, 0, 0, 1, 0, 12'o0);
        // R10 forbidden word without valid
        cyc("R10", 0, 12'o6046, 0, 0, 0, 1, 0, 12'o0);
        // R3 I/O transfer traps, R7 latch
        cyc("R3", 1, 12'o6046, 0, 0, 1, 0, 1, 12'o6046);
        // R8 sticky, then acknowledge; R7 word held
        cyc("R8", 0, 12'o0000, 0, 0, 0, 0, 1, 12'o6046);
        cyc("R8", 0, 12'o0000, 0, 1, 0, 0, 0, 12'o6046);
        // R4 halt traps
        cyc("R9", 0, 12'o0000, 1, 0, 0, 0, 0, 12'o6046);
        cyc("R9", 1, 12'o5200, 0, 0, 0, 1, 0, 12'o6046);
        cyc("R4", 1, 12'o7402, 0, 0, 1, 0, 1, 12'o7402);
        cyc("R8", 0, 12'o0000, 0, 1, 0, 0, 0, 12'o7402);
        // R5 load-switches form, left unacknowledged
        cyc("R9", 0, 12'o0000, 1, 0, 0, 0, 0, 12'o7402);
        cyc("R9", 1, 12'o5200, 0, 0, 0, 1, 0, 12'o7402);
        cyc("R5", 1, 12'o7604, 0, 0, 1, 0, 1, 12'o7604);
        // R8 trap and acknowledge in one cycle: trap wins (R5 OR-switches form)
        cyc("R9", 0, 12'o0000, 1, 0, 0, 0, 1, 12'o7604);
        cyc("R9", 1, 12'o5200, 0, 0, 0, 1, 1, 12'o7604);
        cyc("R8", 1, 12'o7404, 0, 1, 1, 0, 1, 12'o7404);
        cyc("R8", 0, 12'o0000, 0, 1, 0, 0, 0, 12'o7404);
        // R3 field-switch transfer traps
        cyc("R9", 0, 12'o0000, 1, 0, 0, 0, 0, 12'o7404);
        cyc("R9", 1, 12'o5200, 0, 0, 0, 1, 0, 12'o7404);
        cyc("R3", 1, 12'o6211, 0, 0, 1, 0, 1, 12'o6211);
        cyc("R8", 0, 12'o0000, 0, 1, 0, 0, 0, 12'o6211);

        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule